// File: doc/BRIEF.md
# Paged Table Read Unit

This block lets a processor read constant data out of a 24-bit-wide instruction memory as if it were ordinary 16-bit data. The processor loads an 8-bit page value into a small register, then issues a read request carrying a 16-bit offset. The page sits above the offset to form a 24-bit byte address. Bit 0 of that address picks a byte within a 16-bit lane. The memory is seen as two 16-bit lanes side by side at the same address. The low lane holds bits 15:0 of each instruction word. The high lane holds bits 23:16 in its lower byte, and its upper byte does not exist and always reads as zero.

A request selects the lane (low or high) and the access size (word or byte). The unit issues one synchronous read to the memory port, shapes the returned word, and presents a 16-bit result together with a one-cycle done strobe a fixed number of cycles after the request was accepted. Byte results are zero-extended into the 16-bit result. Addresses that fall in the unimplemented gap between the end of user memory and the start of configuration space read as zero without touching the memory. While a read is in flight, the unit holds off new requests by dropping its ready output.

Top module: `tblrd_unit`

## Requirements
- R1: After reset the page register reads 0x0000, req_ready is 1, done is 0, result is 0x0000 and mem_rd_en is 0.
- R2: A page write with pg_we stores pg_wdata[7:0]; pg_rdata returns {8'h00, page} on the next cycle, so bits 15:8 always read as zero.
- R3: The memory word address is {page, offset[15:1]}, using the page value held when the request was accepted. An offset of 0xFFFF stays inside the current page and never carries into the page bits.
- R4: Low lane, word size (req_hi=0, req_byte=0): result = word[15:0]; offset bit 0 has no effect.
- R5: Low lane, byte size (req_hi=0, req_byte=1): result = {8'h00, word[7:0]} when offset bit 0 is 0, and {8'h00, word[15:8]} when it is 1.
- R6: High lane, word size (req_hi=1, req_byte=0): result = {8'h00, word[23:16]}, whatever offset bit 0 is.
- R7: High lane, byte size (req_hi=1, req_byte=1): result = {8'h00, word[23:16]} when offset bit 0 is 0, and 0x0000 when it is 1.
- R8: A request is accepted on a rising edge where req_valid and req_ready are both 1. done is high for exactly the one cycle that follows the fifth rising edge after acceptance. result is valid then and holds until the next done.
- R9: req_ready is 0 from the edge that accepts a request until done rises. req_valid while req_ready is 0 is ignored: it causes no memory read, no extra done and no change to the pending result.
- R10: A byte address at or above USER_END and below CFG_BASE (defaults 0x02C000 and 0x800000) returns 0x0000 in every mode and issues no memory read.
- R11: A page write while a read is in flight does not change that read's address or result. It does take effect for later reads and for readback.
- R12: Each accepted request outside the gap raises mem_rd_en for exactly one cycle, starting in the cycle after acceptance. The memory returns data on mem_rdata one edge after it samples the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pg_we | input | 1 | Page register write strobe |
| pg_wdata | input | 16 | Page write data; only bits 7:0 are stored |
| pg_rdata | output | 16 | Page register readback, upper byte zero |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_ofs | input | 16 | Offset within the page; bit 0 is the byte select |
| req_hi | input | 1 | 1 selects the high lane, 0 the low lane |
| req_byte | input | 1 | 1 selects byte size, 0 word size |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 23 | Memory word address |
| mem_rdata | input | 24 | Memory read data, valid one edge after the strobe |
| done | output | 1 | One-cycle result strobe |
| result | output | 16 | Shaped read result |

## Verification
Every result appears on the fifth rising edge after the edge that accepts the request. The memory strobe is due in the cycle after that edge. A page readback is due one edge after the write. The bench drives inputs on falling edges and, after acceptance, walks one edge at a time. At each falling edge it checks that done is low for edges one to four, high after edge five and low again after edge six. It compares result and the memory address seen by its memory model only at edge five, then checks that result still holds at edge six. The hold-off and mid-flight page-write cases use the same edge count and also check that nothing extra happens in the cycles after done.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  localparam int WORD_W = 24;
  localparam int RES_W  = 16;

  // Shape a fetched 24-bit word into the 16-bit result for the selected lane/size.
  function automatic logic [RES_W-1:0] shape_result(
    input logic [WORD_W-1:0] w,
    input logic              hi,
    input logic              byte_m,
    input logic              b0
  );
    logic [RES_W-1:0] r;
    unique case ({hi, byte_m})
      2'b00: r = w[15:0];
      2'b01: r = b0 ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
      2'b10: r = {8'h00, w[23:16]};
      default: r = b0 ? 16'h0000 : {8'h00, w[23:16]};
    endcase
    return r;
  endfunction

  // True when a byte address lies in the unimplemented gap [lo, hi).
  function automatic logic in_gap(
    input logic [31:0] ea,
    input logic [31:0] lo,
    input logic [31:0] hi
  );
    return (ea >= lo) && (ea < hi);
  endfunction

endpackage

// File: rtl/tbr_page_reg.sv
module tbr_page_reg #(
  parameter int PAGE_W = 8,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [PAGE_W-1:0] page,
  output logic [REG_W-1:0]  rdata
);

  localparam int PAD_W = REG_W - PAGE_W;

  logic [PAGE_W-1:0] page_q;
  logic [PAD_W-1:0]  unused_wr_hi;

  assign unused_wr_hi = wdata[REG_W-1:PAGE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  page_q <= '0;
    else if (we) page_q <= wdata[PAGE_W-1:0];
  end

  assign page  = page_q;
  assign rdata = {{PAD_W{1'b0}}, page_q};

  assert_page_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (page == $past(wdata[PAGE_W-1:0])));

  assert_page_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(page));

endmodule

// File: rtl/tbr_ctrl.sv
module tbr_ctrl #(
  parameter int LATENCY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic accept,
  output logic issue,
  output logic capture,
  output logic finish,
  output logic done
);

  localparam int CW = $clog2(LATENCY + 1);

  generate
    if (LATENCY < 3) begin : g_bad_latency
      $error("tbr_ctrl: LATENCY must be at least 3");
    end
  endgenerate

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign req_ready = !busy_q;
  assign accept    = req_valid && !busy_q;
  assign issue     = busy_q && (cnt_q == CW'(1));
  assign capture   = busy_q && (cnt_q == CW'(2));
  assign finish    = busy_q && (cnt_q == CW'(LATENCY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(1);
      end else if (finish) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + CW'(1);
      end
    end
  end

  assign done = done_q;

  // Independent age counter for the latency window.
  logic [CW-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        age_q <= '0;
    else if (accept)                   age_q <= '0;
    else if (age_q != CW'(LATENCY))    age_q <= age_q + CW'(1);
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (age_q == CW'(LATENCY)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_one_issue_R12: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);

endmodule

// File: rtl/tbr_fetch.sv
module tbr_fetch #(
  parameter int          PAGE_W   = 8,
  parameter int          OFS_W    = 16,
  parameter logic [31:0] USER_END = 32'h0002_C000,
  parameter logic [31:0] CFG_BASE = 32'h0080_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        accept,
  input  logic                        capture,
  input  logic                        finish,
  input  logic [PAGE_W-1:0]           page,
  input  logic [OFS_W-1:0]            req_ofs,
  input  logic                        req_hi,
  input  logic                        req_byte,
  input  logic [tbr_pkg::WORD_W-1:0]  mem_rdata,
  output logic [PAGE_W+OFS_W-2:0]     mem_addr,
  output logic                        gap,
  output logic [tbr_pkg::RES_W-1:0]   result
);

  localparam int EA_W = PAGE_W + OFS_W;

  logic [EA_W-1:0]            ea_q;
  logic                       hi_q, byte_q, gap_q;
  logic [tbr_pkg::WORD_W-1:0] word_q;
  logic [tbr_pkg::RES_W-1:0]  res_q;
  logic [EA_W-1:0]            ea_new;

  assign ea_new = {page, req_ofs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q   <= '0;
      hi_q   <= 1'b0;
      byte_q <= 1'b0;
      gap_q  <= 1'b0;
      word_q <= '0;
      res_q  <= '0;
    end else begin
      if (accept) begin
        ea_q   <= ea_new;
        hi_q   <= req_hi;
        byte_q <= req_byte;
        gap_q  <= tbr_pkg::in_gap(32'(ea_new), USER_END, CFG_BASE);
      end
      if (capture) word_q <= gap_q ? '0 : mem_rdata;
      if (finish)  res_q  <= tbr_pkg::shape_result(word_q, hi_q, byte_q, ea_q[0]);
    end
  end

  assign mem_addr = ea_q[EA_W-1:1];
  assign gap      = gap_q;
  assign result   = res_q;

  assert_phantom_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && hi_q && byte_q && ea_q[0]) |=> (result == '0));

  assert_gap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && gap_q) |=> (result == '0));

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result));

endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit #(
  parameter int          PAGE_W   = 8,
  parameter int          OFS_W    = 16,
  parameter int          REG_W    = 16,
  parameter int          LATENCY  = 5,
  parameter logic [31:0] USER_END = 32'h0002_C000,
  parameter logic [31:0] CFG_BASE = 32'h0080_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pg_we,
  input  logic [REG_W-1:0]            pg_wdata,
  output logic [REG_W-1:0]            pg_rdata,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [OFS_W-1:0]            req_ofs,
  input  logic                        req_hi,
  input  logic                        req_byte,
  output logic                        mem_rd_en,
  output logic [PAGE_W+OFS_W-2:0]     mem_addr,
  input  logic [tbr_pkg::WORD_W-1:0]  mem_rdata,
  output logic                        done,
  output logic [tbr_pkg::RES_W-1:0]   result
);

  logic [PAGE_W-1:0] page;
  logic accept, issue, capture, finish, gap;

  tbr_page_reg #(.PAGE_W(PAGE_W), .REG_W(REG_W)) u_page (
    .clk(clk), .rst_n(rst_n), .we(pg_we), .wdata(pg_wdata),
    .page(page), .rdata(pg_rdata)
  );

  tbr_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .accept(accept), .issue(issue), .capture(capture), .finish(finish),
    .done(done)
  );

  tbr_fetch #(
    .PAGE_W(PAGE_W), .OFS_W(OFS_W), .USER_END(USER_END), .CFG_BASE(CFG_BASE)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .finish(finish), .page(page), .req_ofs(req_ofs), .req_hi(req_hi),
    .req_byte(req_byte), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .gap(gap), .result(result)
  );

  assign mem_rd_en = issue && !gap;

  assert_no_gap_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !tbr_pkg::in_gap(32'({mem_addr, 1'b0}), USER_END, CFG_BASE));

  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$rose(done) && !accept) |=> $stable(mem_addr));

endmodule

// File: tb/tblrd_unit_tb.sv
module tblrd_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_we = 1'b0;
  logic [15:0] pg_wdata = '0;
  logic [15:0] pg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_ofs = '0;
  logic        req_hi = 1'b0;
  logic        req_byte = 1'b0;
  logic        mem_rd_en;
  logic [22:0] mem_addr;
  logic [23:0] mem_rdata = '0;
  logic        done;
  logic [15:0] result;

  int n_checks = 0;
  int n_errors = 0;
  int rd_cnt = 0;
  logic [22:0] last_addr = '0;

  always #4 clk = ~clk;

  tblrd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .pg_we(pg_we), .pg_wdata(pg_wdata),
    .pg_rdata(pg_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_ofs(req_ofs), .req_hi(req_hi), .req_byte(req_byte),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .done(done), .result(result)
  );

  function automatic logic [23:0] memf(input logic [22:0] a);
    return {a[7:0] ^ 8'hC3, a[14:7] ^ 8'h5A, a[7:0] ^ 8'h96};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= memf(mem_addr);
      last_addr <= mem_addr;
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  function automatic logic [15:0] expect_res(input logic [7:0] pg, input logic [15:0] ofs,
                                              input logic hi, input logic byt);
    logic [23:0] ea;
    logic [23:0] w;
    ea = {pg, ofs};
    w  = (ea >= 24'h02C000 && ea < 24'h800000) ? 24'h0 : memf(ea[23:1]);
    if (!hi && !byt) return w[15:0];
    if (!hi &&  byt) return ofs[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    if (hi && !byt)  return {8'h00, w[23:16]};
    return ofs[0] ? 16'h0000 : {8'h00, w[23:16]};
  endfunction

  task automatic set_page(input logic [7:0] v);
    @(negedge clk);
    pg_we = 1'b1;
    pg_wdata = {8'hA5, v};
    @(negedge clk);
    pg_we = 1'b0;
    check(pg_rdata == {8'h00, v}, "R2 page readback", 32'(pg_rdata), 32'({8'h00, v}));
  endtask

  task automatic do_read(input logic [7:0] pg, input logic [15:0] ofs, input logic hi, input logic byt);
    logic [15:0] exp;
    logic        gap;
    int          rd0;
    string       tag;
    exp = expect_res(pg, ofs, hi, byt);
    gap = ({pg, ofs} >= 24'h02C000) && ({pg, ofs} < 24'h800000);
    tag = gap ? "R10 gap" : (!hi && !byt) ? "R4 low word" : (!hi) ? "R5 low byte" :
          (!byt) ? "R6 high word" : "R7 high byte";
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 32'd1);
    rd0 = rd_cnt;
    req_valid = 1'b1; req_ofs = ofs; req_hi = hi; req_byte = byt;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(done == (k == 5), "R8 done timing", 32'(done), 32'(k == 5));
      if (k == 5) begin
        check(result == exp, tag, 32'(result), 32'(exp));
        check(rd_cnt - rd0 == (gap ? 0 : 1), "R12 one memory read", 32'(rd_cnt - rd0), 32'(gap ? 0 : 1));
        if (!gap)
          check(last_addr == {pg, ofs[15:1]}, "R3 word address", 32'(last_addr), 32'({pg, ofs[15:1]}));
      end
      if (k == 6) check(result == exp, "R8 result hold", 32'(result), 32'(exp));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0]  pages [8];
    logic [15:0] offs  [8];
    logic [15:0] exp;
    pages = '{8'h00, 8'h01, 8'h02, 8'h05, 8'h7F, 8'h80, 8'hF8, 8'hFF};
    offs  = '{16'h0000, 16'h0001, 16'h5A5B, 16'hBFFE, 16'hBFFF, 16'hC000, 16'hFFFE, 16'hFFFF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pg_rdata == 16'h0000, "R1 page reset", 32'(pg_rdata), 32'd0);
    check(req_ready == 1'b1, "R1 ready reset", 32'(req_ready), 32'd1);
    check(done == 1'b0, "R1 done reset", 32'(done), 32'd0);
    check(result == 16'h0000, "R1 result reset", 32'(result), 32'd0);
    check(mem_rd_en == 1'b0, "R1 no read at reset", 32'(mem_rd_en), 32'd0);

    // Sweep pages x offsets x lane/size modes (R3..R7, R10).
    for (int p = 0; p < 8; p++) begin
      set_page(pages[p]);
      for (int o = 0; o < 8; o++)
        for (int m = 0; m < 4; m++)
          do_read(pages[p], offs[o], m[1], m[0]);
    end

    // R9: requests held off while busy.
    set_page(8'h01);
    exp = expect_res(8'h01, 16'h0010, 1'b0, 1'b0);
    begin
      int rd0;
      rd0 = rd_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_ofs = 16'h0010; req_hi = 1'b0; req_byte = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_ofs = 16'h0020; req_hi = 1'b1;
      for (int k = 1; k <= 8; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (k <= 4) check(req_ready == 1'b0, "R9 ready low while busy", 32'(req_ready), 32'd0);
        if (k == 4) req_valid = 1'b0;
        check(done == (k == 5), "R9 no extra done", 32'(done), 32'(k == 5));
        if (k == 5) check(result == exp, "R9 result of first request", 32'(result), 32'(exp));
      end
      check(rd_cnt - rd0 == 1, "R9 single memory read", 32'(rd_cnt - rd0), 32'd1);
    end

    // R11: page write during flight does not disturb it.
    set_page(8'h01);
    exp = expect_res(8'h01, 16'h0100, 1'b1, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_ofs = 16'h0100; req_hi = 1'b1; req_byte = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    pg_we = 1'b1; pg_wdata = 16'h0080;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      pg_we = 1'b0;
      if (k == 5) begin
        check(done == 1'b1, "R11 done", 32'(done), 32'd1);
        check(result == exp, "R11 result uses old page", 32'(result), 32'(exp));
        check(last_addr == {8'h01, 15'h0080}, "R11 address uses old page", 32'(last_addr), 32'({8'h01, 15'h0080}));
      end
    end
    check(pg_rdata == 16'h0080, "R11 new page readback", 32'(pg_rdata), 32'h80);
    do_read(8'h80, 16'h0100, 1'b1, 1'b0);

    finish_run();
  end

endmodule